// File: doc/BRIEF.md
# Multichannel Chipping Sequence Sequencer

This block feeds a bank of parallel modulate-and-integrate sampling channels. Every channel receives its own periodic binary chipping stream, one bit per bit period. An integration period lasts exactly `NBITS` bit periods. The set of sequences can differ from one integration period to the next, cycling through `NVER` stored versions.

All channels share one integration-period timebase. The same timebase also drives the ping-pong control of each channel's integrator pair. One integrator integrates while the other holds its value for the ADC. The holding integrator is cleared during the final bit period before it takes over again, and an ADC sample strobe marks the start of each hold.

Sequence words are loaded one channel and one version at a time through a write port, while the run input is low. Raising run starts every channel together on bit 0 of version 0.

Top module: `chip_seq_sequencer`

## Requirements
- R1: A chipping value of +1 is driven as `chip_pos`=1, `chip_neg`=0, and a value of -1 as `chip_pos`=0, `chip_neg`=1. While idle, both are 0, and the two are never 1 together on any channel.
- R2: While running, channel c plays bit `idx` (LSB first) of the word stored for channel c and the current version. A `bit_en` high at a rising edge advances `idx` by one. The chipping outputs follow at the next rising edge.
- R3: After bit `NBITS-1` is consumed, `idx` returns to 0 and the version advances by one modulo `NVER`. Version 0 follows version `NVER-1`.
- R4: `wr_addr` carries the channel in its low `bits_for(NCH)` bits and the version above them. A write takes effect only when `wr_en` is high and `run` is low. Writes made while `run` is high leave the stored words unchanged.
- R5: At the first rising edge that samples `run` high, all channels start on bit 0 of version 0, and that bit appears on the outputs at the next edge. An edge that samples `run` low returns the block to idle, and the outputs show idle one edge later.
- R6: Idle: both integrate enables are 1. Running: exactly one is 1. The left integrator integrates in the first integration period, and the roles swap at every period boundary.
- R7: `route_right`=1 routes the right integrator to the ADC, and 0 routes the left one. While running, it always selects the integrator that is holding. While idle, it is 0.
- R8: During the last bit period of each integration period, the holding integrator's clear output is 1. At all other times both clear outputs are 0.
- R9: `sample_stb` is a single-cycle pulse, once per integration period. It is asserted in the cycle after `route_right` changes at a period boundary, while `route_right` still points at the holding integrator.
- R10: While `rst` is high at a rising edge, the outputs go to idle: chip outputs 0, both integrate enables 1, clears 0, `route_right` 0, `sample_stb` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Run enable; low holds the block idle and opens the write port |
| bit_en | input | 1 | Bit-period advance enable |
| wr_en | input | 1 | Sequence write enable |
| wr_addr | input | bits_for(NVER)+bits_for(NCH) | {version, channel} of the word to write |
| wr_data | input | NBITS | Sequence word, bit 0 played first |
| chip_pos | output | NCH | Per-channel positive chipping drive |
| chip_neg | output | NCH | Per-channel negative chipping drive |
| integ_en_l | output | 1 | Left integrator integrate enable |
| integ_en_r | output | 1 | Right integrator integrate enable |
| integ_clr_l | output | 1 | Left integrator clear |
| integ_clr_r | output | 1 | Right integrator clear |
| route_right | output | 1 | ADC routing select, 1 = right integrator |
| sample_stb | output | 1 | ADC sample strobe |

## Verification
Each control input sampled at a rising edge changes the internal timebase at that edge, and the registered outputs show the result one edge later. A `bit_en` or `run` change is therefore visible two edges after it is driven. A boundary-crossing advance shows up on `route_right` at the following edge and on `sample_stb` one edge after that. The reference model keeps the same edge accounting: at each edge it first computes the outputs from its pre-edge state, then applies writes and updates the state. It is compared with the outputs at every falling edge. Directed checks count edges from the rise of `run` and predict each channel's bit directly from the loaded pattern words, not from the model's memory. This lets them catch writes that should have been ignored.

// File: rtl/chipseq_pkg.sv
package chipseq_pkg;
  function automatic int bits_for(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  typedef enum logic {
    SIDE_LEFT  = 1'b0,
    SIDE_RIGHT = 1'b1
  } side_e;
endpackage

// File: rtl/cs_seqmem.sv
module cs_seqmem #(
  parameter int NCH   = 16,
  parameter int NBITS = 16,
  parameter int NVER  = 4,
  localparam int VER_W = chipseq_pkg::bits_for(NVER),
  localparam int CH_W  = chipseq_pkg::bits_for(NCH)
) (
  input  logic                   clk,
  input  logic                   wr_ok,
  input  logic [VER_W-1:0]       wr_ver,
  input  logic [CH_W-1:0]        wr_ch,
  input  logic [NBITS-1:0]       wr_data,
  input  logic [VER_W-1:0]       rd_ver,
  output logic [NCH*NBITS-1:0]   rows
);
  // One small RAM per channel, written one word at a time, read synchronously.
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [NBITS-1:0] store [NVER];
    logic [NBITS-1:0] rd_q;

    always_ff @(posedge clk) begin
      if (wr_ok && (wr_ch == CH_W'(g)))
        store[wr_ver] <= wr_data;
      rd_q <= store[rd_ver];
    end

    assign rows[g*NBITS +: NBITS] = rd_q;
  end
endmodule

// File: rtl/cs_timebase.sv
module cs_timebase
  import chipseq_pkg::*;
#(
  parameter int NBITS = 16,
  parameter int NVER  = 4,
  localparam int IDX_W = chipseq_pkg::bits_for(NBITS),
  localparam int VER_W = chipseq_pkg::bits_for(NVER)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             bit_en,
  output logic             running_q,
  output logic [IDX_W-1:0] idx_q,
  output logic [VER_W-1:0] ver_nxt,
  output side_e            side_q,
  output logic             swap_q
);
  logic [VER_W-1:0] ver_q;
  logic adv, last, wrap;

  assign adv  = running_q & bit_en;
  assign last = (idx_q == IDX_W'(NBITS-1));
  assign wrap = adv & last;

  always_comb begin
    if (rst || !run)
      ver_nxt = '0;
    else if (wrap)
      ver_nxt = (ver_q == VER_W'(NVER-1)) ? '0 : ver_q + 1'b1;
    else
      ver_nxt = ver_q;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      running_q <= 1'b0;
      idx_q     <= '0;
      ver_q     <= '0;
      side_q    <= SIDE_LEFT;
      swap_q    <= 1'b0;
    end else begin
      running_q <= 1'b1;
      swap_q    <= wrap;
      ver_q     <= ver_nxt;
      if (adv)
        idx_q <= last ? '0 : idx_q + 1'b1;
      if (wrap)
        side_q <= (side_q == SIDE_LEFT) ? SIDE_RIGHT : SIDE_LEFT;
    end
  end

  // R2: one step per enabled bit inside a period
  a_r2_idx_step: assert property (@(posedge clk) disable iff (rst)
    (run && running_q && bit_en && !last) |=> (idx_q == $past(idx_q) + 1'b1));

  // R2: no enable, no movement
  a_r2_idx_hold: assert property (@(posedge clk) disable iff (rst)
    (run && !(running_q && bit_en)) |=> $stable(idx_q));

  // R3: period boundary wraps index, swaps sides, advances version modulo NVER
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (run && running_q && bit_en && last) |=>
      (idx_q == '0 && side_q != $past(side_q) &&
       ver_q == (($past(ver_q) == VER_W'(NVER-1)) ? '0 : $past(ver_q) + 1'b1)));

  // R5: run low returns the timebase to its start point
  a_r5_idle: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!running_q && idx_q == '0 && ver_q == '0 && side_q == SIDE_LEFT));
endmodule

// File: rtl/cs_outstage.sv
module cs_outstage
  import chipseq_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int NBITS = 16,
  localparam int IDX_W = chipseq_pkg::bits_for(NBITS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 running_q,
  input  logic [IDX_W-1:0]     idx_q,
  input  side_e                side_q,
  input  logic                 swap_q,
  input  logic [NCH*NBITS-1:0] rows,
  output logic [NCH-1:0]       chip_pos,
  output logic [NCH-1:0]       chip_neg,
  output logic                 integ_en_l,
  output logic                 integ_en_r,
  output logic                 integ_clr_l,
  output logic                 integ_clr_r,
  output logic                 route_right,
  output logic                 sample_stb
);
  logic [NCH-1:0] bit_now;
  logic           last, swap_d;

  assign last = (idx_q == IDX_W'(NBITS-1));

  for (genvar g = 0; g < NCH; g++) begin : g_sel
    logic [NBITS-1:0] word;
    assign word       = rows[g*NBITS +: NBITS];
    assign bit_now[g] = word[idx_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chip_pos    <= '0;
      chip_neg    <= '0;
      integ_en_l  <= 1'b1;
      integ_en_r  <= 1'b1;
      integ_clr_l <= 1'b0;
      integ_clr_r <= 1'b0;
      route_right <= 1'b0;
      swap_d      <= 1'b0;
      sample_stb  <= 1'b0;
    end else begin
      chip_pos    <= running_q ? bit_now  : '0;
      chip_neg    <= running_q ? ~bit_now : '0;
      integ_en_l  <= !running_q || (side_q == SIDE_LEFT);
      integ_en_r  <= !running_q || (side_q == SIDE_RIGHT);
      route_right <= running_q && (side_q == SIDE_LEFT);
      integ_clr_l <= running_q && (side_q == SIDE_RIGHT) && last;
      integ_clr_r <= running_q && (side_q == SIDE_LEFT) && last;
      swap_d      <= running_q && swap_q;
      sample_stb  <= running_q && swap_d;
    end
  end

  // R1: complementary drives never both high
  a_r1_chip_excl: assert property (@(posedge clk) disable iff (rst)
    (chip_pos & chip_neg) == '0);

  // R6: at least one integrator always integrates
  a_r6_integ_cover: assert property (@(posedge clk) disable iff (rst)
    (integ_en_l || integ_en_r));

  // R8: only a non-integrating integrator is ever cleared
  a_r8_clr_holding: assert property (@(posedge clk) disable iff (rst)
    ((integ_clr_l -> !integ_en_l) && (integ_clr_r -> !integ_en_r)));

  // R9: strobe is one cycle, routing steady, aimed at the holding side
  a_r9_stb_single: assert property (@(posedge clk) disable iff (rst)
    sample_stb |=> !sample_stb);
  a_r9_stb_target: assert property (@(posedge clk) disable iff (rst)
    sample_stb |-> (route_right == integ_en_l && integ_en_l != integ_en_r));
  a_r9_stb_after_swap: assert property (@(posedge clk) disable iff (rst)
    $rose(sample_stb) |-> $stable(route_right));
endmodule

// File: rtl/chip_seq_sequencer.sv
module chip_seq_sequencer
  import chipseq_pkg::*;
#(
  parameter int NCH   = 16,
  parameter int NBITS = 16,
  parameter int NVER  = 4,
  localparam int VER_W = chipseq_pkg::bits_for(NVER),
  localparam int CH_W  = chipseq_pkg::bits_for(NCH),
  localparam int IDX_W = chipseq_pkg::bits_for(NBITS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   run,
  input  logic                   bit_en,
  input  logic                   wr_en,
  input  logic [VER_W+CH_W-1:0]  wr_addr,
  input  logic [NBITS-1:0]       wr_data,
  output logic [NCH-1:0]         chip_pos,
  output logic [NCH-1:0]         chip_neg,
  output logic                   integ_en_l,
  output logic                   integ_en_r,
  output logic                   integ_clr_l,
  output logic                   integ_clr_r,
  output logic                   route_right,
  output logic                   sample_stb
);
  logic [VER_W-1:0]     wr_ver, ver_nxt;
  logic [CH_W-1:0]      wr_ch;
  logic                 wr_ok, running_q, swap_q;
  logic [IDX_W-1:0]     idx_q;
  side_e                side_q;
  logic [NCH*NBITS-1:0] rows;

  assign wr_ch  = wr_addr[CH_W-1:0];
  assign wr_ver = wr_addr[CH_W +: VER_W];
  assign wr_ok  = wr_en && !run && (int'(wr_ver) < NVER);

  cs_timebase #(.NBITS(NBITS), .NVER(NVER)) tb_i (
    .clk(clk), .rst(rst), .run(run), .bit_en(bit_en),
    .running_q(running_q), .idx_q(idx_q), .ver_nxt(ver_nxt),
    .side_q(side_q), .swap_q(swap_q)
  );

  cs_seqmem #(.NCH(NCH), .NBITS(NBITS), .NVER(NVER)) mem_i (
    .clk(clk), .wr_ok(wr_ok), .wr_ver(wr_ver), .wr_ch(wr_ch),
    .wr_data(wr_data), .rd_ver(ver_nxt), .rows(rows)
  );

  cs_outstage #(.NCH(NCH), .NBITS(NBITS)) out_i (
    .clk(clk), .rst(rst), .running_q(running_q), .idx_q(idx_q),
    .side_q(side_q), .swap_q(swap_q), .rows(rows),
    .chip_pos(chip_pos), .chip_neg(chip_neg),
    .integ_en_l(integ_en_l), .integ_en_r(integ_en_r),
    .integ_clr_l(integ_clr_l), .integ_clr_r(integ_clr_r),
    .route_right(route_right), .sample_stb(sample_stb)
  );

  // R4: the write port is closed while running
  a_r4_no_write_running: assert property (@(posedge clk) disable iff (rst)
    run |-> !wr_ok);
endmodule

// File: tb/chip_seq_sequencer_tb_top.sv
`timescale 1ns/1ps
module chip_seq_sequencer_tb_top;
  localparam int NCH = 16, NBITS = 16, NVER = 4;
  localparam int VER_W = 2, CH_W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1, run = 1'b0, bit_en = 1'b0, wr_en = 1'b0;
  logic [VER_W+CH_W-1:0] wr_addr = '0;
  logic [NBITS-1:0] wr_data = '0;
  logic [NCH-1:0] chip_pos, chip_neg;
  logic integ_en_l, integ_en_r, integ_clr_l, integ_clr_r, route_right, sample_stb;

  always #2.5 clk = ~clk;

  chip_seq_sequencer #(.NCH(NCH), .NBITS(NBITS), .NVER(NVER)) dut_i (
    .clk(clk), .rst(rst), .run(run), .bit_en(bit_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .chip_pos(chip_pos), .chip_neg(chip_neg),
    .integ_en_l(integ_en_l), .integ_en_r(integ_en_r), .integ_clr_l(integ_clr_l),
    .integ_clr_r(integ_clr_r), .route_right(route_right), .sample_stb(sample_stb)
  );

  int n_cmp = 0, n_bad = 0;
  bit cmp_en = 1'b0, done = 1'b0;
  int salt = 0;

  function automatic logic [NBITS-1:0] pat(int v, int c, int s);
    return NBITS'((c * 16'h1d35) ^ (v * 16'h0b71) ^ 16'ha5c3 ^ (c << v) ^ (s * 16'h3c6f));
  endfunction

  function automatic logic [NCH-1:0] col(int v, int j, int s);
    logic [NCH-1:0] r;
    for (int c = 0; c < NCH; c++) r[c] = pat(v, c, s)[j];
    return r;
  endfunction

  task automatic chk(string tag, logic [NCH-1:0] act, logic [NCH-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [NBITS-1:0] m_mem [NVER][NCH];
  bit m_running, m_side, m_swap, m_swapd;
  int m_idx, m_ver;
  logic [NCH-1:0] e_cp, e_cn;
  bit e_il, e_ir, e_cl, e_cr, e_rr, e_stb;

  always @(posedge clk) begin
    bit adv, wrap;
    if (rst) begin
      e_cp = '0; e_cn = '0; e_il = 1; e_ir = 1; e_cl = 0; e_cr = 0; e_rr = 0; e_stb = 0;
      m_swapd = 0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        e_cp[c] = m_running &  m_mem[m_ver][c][m_idx];
        e_cn[c] = m_running & ~m_mem[m_ver][c][m_idx];
      end
      e_il  = !m_running || !m_side;
      e_ir  = !m_running ||  m_side;
      e_rr  =  m_running && !m_side;
      e_cl  =  m_running &&  m_side && (m_idx == NBITS-1);
      e_cr  =  m_running && !m_side && (m_idx == NBITS-1);
      e_stb =  m_running && m_swapd;
      m_swapd = m_running && m_swap;
    end
    if (wr_en && !run) m_mem[int'(wr_addr[CH_W +: VER_W])][int'(wr_addr[CH_W-1:0])] = wr_data;
    if (rst || !run) begin
      m_running = 0; m_idx = 0; m_ver = 0; m_side = 0; m_swap = 0;
    end else begin
      adv  = m_running && bit_en;
      wrap = adv && (m_idx == NBITS-1);
      m_swap = wrap;
      if (adv) m_idx = wrap ? 0 : m_idx + 1;
      if (wrap) begin m_ver = (m_ver + 1) % NVER; m_side = !m_side; end
      m_running = 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      chk("R2 chip_pos", chip_pos, e_cp);
      chk("R1 chip_neg", chip_neg, e_cn);
      chk("R6 integ_en", {integ_en_l, integ_en_r}, {e_il, e_ir});
      chk("R7 route_right", route_right, e_rr);
      chk("R8 integ_clr", {integ_clr_l, integ_clr_r}, {e_cl, e_cr});
      chk("R9 sample_stb", sample_stb, e_stb);
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic load_all(int s);
    for (int v = 0; v < NVER; v++)
      for (int c = 0; c < NCH; c++) begin
        wr_en = 1; wr_addr = {VER_W'(v), CH_W'(c)}; wr_data = pat(v, c, s);
        tick();
      end
    wr_en = 0;
  endtask

  task automatic check_idle(string tag);
    chk({tag, " chip_pos"}, chip_pos, '0);
    chk({tag, " chip_neg"}, chip_neg, '0);
    chk({tag, " ctrl"}, {integ_en_l, integ_en_r, integ_clr_l, integ_clr_r, route_right, sample_stb},
        6'b110000);
  endtask

  initial begin
    int unsigned lf = 32'h1234_5678;
    repeat (4) tick();
    cmp_en = 1;
    check_idle("R10");
    rst = 0;
    load_all(0);
    // Directed run with one bit per cycle; pattern words predict every bit.
    run = 1; bit_en = 1;
    @(posedge clk);
    for (int j = 0; j < NBITS * NVER + NBITS + 3; j++) begin
      @(posedge clk);
      @(negedge clk);
      if (j == 0) chk("R5 start bit0 ver0", chip_pos, col(0, 0, 0));
      else if (j % NBITS == 0) chk("R3 version step", chip_pos, col((j / NBITS) % NVER, 0, 0));
      else chk("R2 bit walk", chip_pos, col((j / NBITS) % NVER, j % NBITS, 0));
      wr_en = (j == 7); wr_addr = '0; wr_data = ~pat(0, 0, 0);
    end
    wr_en = 0;
    run = 0; bit_en = 0;
    tick(); tick();
    check_idle("R5 stop");
    // Restart: ignored write must not have altered version 0.
    run = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R4 write ignored", chip_pos, col(0, 0, 0));
    for (int k = 0; k < 600; k++) begin
      lf = lf * 32'd1103515245 + 32'd12345;
      bit_en = lf[20] | lf[21];
      tick();
    end
    rst = 1; tick(); tick();
    check_idle("R10 mid");
    rst = 0; run = 0;
    salt = 1;
    load_all(1);
    run = 1;
    for (int k = 0; k < 900; k++) begin
      lf = lf * 32'd1103515245 + 32'd12345;
      bit_en = lf[19];
      if (k == 400) run = 0;
      if (k == 403) run = 1;
      tick();
    end
    run = 0; tick(); tick();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule